// File: doc/BRIEF.md
# Phase Delay Scan and Clean-Window Centring

The block tunes the receive-phase delay of a capture stage it does not own. After a start pulse it steps the delay through every tap in ascending order. For each tap it pulses a clear to an external error counter, waits a fixed number of dwell-timer ticks, and then samples that counter. A tap whose sampled count is zero is "clean".

At the end of the sweep the block finds the longest run of adjacent clean taps and reports where that run starts and how wide it is. It applies the run's centre as the new delay. If there is no clean tap, it raises a no-window flag and returns the delay to its reset default.

The dwell is a count of ticks from a shared timer. A real system can use a one-second dwell, and a simulation can use a few ticks. Every pin is plain control or status, so no valid/ready stream is involved. The error count is read in one fixed cycle and is never back-pressured. The results hold steady until the next start.

Top module: `dscan_window_finder`

## Requirements
- R1: While reset is low, and in the cycle after reset is released, `delay_o` equals `RESET_DLY`. In the same cycles `valid_o`, `nowin_o` and `clr_o` are low.
- R2: A start pulse sweeps taps 0 to `NUM_TAPS-1` in ascending order and pulses `clr_o` for exactly one cycle per tap. While each pulse is high, `delay_o` already shows that tap.
- R3: After each clear, the block counts `DWELL_TICKS` cycles with `tick_i` high before it samples. With `tick_i` held high, the clear pulses are `DWELL_TICKS+2` cycles apart. With `tick_i` held low, the sweep does not advance.
- R4: A tap is clean exactly when `err_cnt_i` is zero in the cycle after its last dwell tick.
- R5: The reported window is the longest run of adjacent clean taps. Among runs of equal length, the one with the lowest starting tap wins. `win_start_o` is the first tap of the run and `win_width_o` is its length.
- R6: `best_dly_o` equals `win_start_o + (win_width_o-1)/2`, so an even-width window rounds down.
- R7: When the sweep has at least one clean tap, `valid_o` rises and `nowin_o` stays low. `delay_o` then equals `best_dly_o`.
- R8: When the sweep has no clean tap, `nowin_o` rises and `valid_o` stays low. `delay_o` returns to `RESET_DLY`, and `win_start_o`, `win_width_o` and `best_dly_o` are all zero.
- R9: A start pulse that arrives during a sweep is ignored. The sweep continues without restarting and without extra clears.
- R10: A start pulse clears both flags on the next cycle. Once a sweep finishes, its results, its flags and `delay_o` stay stable until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse that begins a sweep; ignored while busy |
| tick_i | input | 1 | Dwell timer tick, one count per high cycle |
| err_cnt_i | input | ERR_W | External error count, sampled once per tap |
| delay_o | output | DLY_W | Delay tap applied to the capture logic |
| clr_o | output | 1 | One-cycle clear strobe for the error counter |
| best_dly_o | output | DLY_W | Centre of the chosen clean window |
| win_start_o | output | DLY_W | First tap of the chosen window |
| win_width_o | output | LEN_W | Number of taps in the chosen window |
| valid_o | output | 1 | A clean window was found |
| nowin_o | output | 1 | No tap was clean |

## Verification
The sweep is run against several kinds of clean-tap mask, each of which separates a different way the design could go wrong:
- a single wide window, which checks the basic centring;
- two equal-length runs, which checks the lowest-start tie-break;
- a shorter run ahead of a longer even-width one, which checks that the longest run wins and that the centre rounds down;
- a lone clean tap on the last position;
- an all-clean mask and an all-dirty mask;
- a few dozen random masks.

The bench models the error counter: it counts ticks on dirty taps and zeroes on each clear. A design that samples before the clear, or before the final tick, would therefore misjudge a clean tap that follows a dirty one.

Separate sweeps hold the tick permanently high to pin the spacing of the clear strobes. They hold it low to show the sweep stalls. They also fire a second start in mid-sweep to show it is ignored.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
  // Sweep sequencer states: one clear cycle, a dwell, one sample cycle per tap.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_DWELL,
    ST_SAMPLE,
    ST_FINISH
  } scan_state_e;
endpackage

// File: rtl/dscan_dwell_timer.sv
// Counts dwell ticks after each clear; flags the tick that completes the dwell.
module dscan_dwell_timer #(
  parameter int DWELL_TICKS = 1000,
  localparam int TW = (DWELL_TICKS > 1) ? $clog2(DWELL_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam logic [TW-1:0] LAST = TW'(DWELL_TICKS - 1);

  logic [TW-1:0] cnt;

  assign done_o = run_i && tick_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || arm_i) begin
      cnt <= '0;
    end else if (run_i && tick_i && !done_o) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dscan_run_tracker.sv
// Tracks the current run of clean taps and the longest one seen so far.
// Strictly-greater replacement keeps the earliest run on a tie.
module dscan_run_tracker #(
  parameter int DLY_W = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic             clean_i,
  input  logic [DLY_W-1:0] tap_i,
  output logic [DLY_W-1:0] best_start_o,
  output logic [LEN_W-1:0] best_len_o
);
  logic [DLY_W-1:0] cur_start;
  logic [LEN_W-1:0] cur_len;
  logic [DLY_W-1:0] run_start;
  logic [LEN_W-1:0] run_len;

  always_comb begin
    run_start = (cur_len == '0) ? tap_i : cur_start;
    run_len   = cur_len + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      cur_start    <= '0;
      cur_len      <= '0;
      best_start_o <= '0;
      best_len_o   <= '0;
    end else if (sample_i) begin
      if (clean_i) begin
        cur_start <= run_start;
        cur_len   <= run_len;
        if (run_len > best_len_o) begin
          best_start_o <= run_start;
          best_len_o   <= run_len;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end
endmodule

// File: rtl/dscan_centre.sv
// Centre of a window, rounding down for even widths.
module dscan_centre #(
  parameter int DLY_W = 4,
  parameter int LEN_W = 4
) (
  input  logic [DLY_W-1:0] start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [DLY_W-1:0] centre_o
);
  logic [LEN_W-1:0] half;

  always_comb begin
    half     = (len_i == '0) ? '0 : ((len_i - 1'b1) >> 1);
    centre_o = start_i + DLY_W'(half);
  end
endmodule

// File: rtl/dscan_window_finder.sv
module dscan_window_finder #(
  parameter int NUM_TAPS    = 13,
  parameter int ERR_W       = 16,
  parameter int DWELL_TICKS = 1000,
  parameter int RESET_DLY   = 0,
  localparam int DLY_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1,
  localparam int LEN_W = $clog2(NUM_TAPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [ERR_W-1:0] err_cnt_i,
  output logic [DLY_W-1:0] delay_o,
  output logic             clr_o,
  output logic [DLY_W-1:0] best_dly_o,
  output logic [DLY_W-1:0] win_start_o,
  output logic [LEN_W-1:0] win_width_o,
  output logic             valid_o,
  output logic             nowin_o
);
  import dscan_pkg::*;

  localparam logic [DLY_W-1:0] LAST_TAP = DLY_W'(NUM_TAPS - 1);
  localparam logic [DLY_W-1:0] RST_TAP  = DLY_W'(RESET_DLY);

  scan_state_e      state;
  logic [DLY_W-1:0] tap;
  logic [DLY_W-1:0] applied_dly;
  logic             go;
  logic             dwell_done;
  logic [DLY_W-1:0] trk_start;
  logic [LEN_W-1:0] trk_len;
  logic [DLY_W-1:0] centre;

  assign go      = (state == ST_IDLE) && start_i;
  assign clr_o   = (state == ST_CLEAR);
  assign delay_o = (state == ST_IDLE) ? applied_dly : tap;

  dscan_dwell_timer #(.DWELL_TICKS(DWELL_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (state == ST_CLEAR),
    .run_i  (state == ST_DWELL),
    .tick_i (tick_i),
    .done_o (dwell_done)
  );

  dscan_run_tracker #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (go),
    .sample_i     (state == ST_SAMPLE),
    .clean_i      (err_cnt_i == '0),
    .tap_i        (tap),
    .best_start_o (trk_start),
    .best_len_o   (trk_len)
  );

  dscan_centre #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_centre (
    .start_i  (trk_start),
    .len_i    (trk_len),
    .centre_o (centre)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tap         <= '0;
      applied_dly <= RST_TAP;
      best_dly_o  <= '0;
      win_start_o <= '0;
      win_width_o <= '0;
      valid_o     <= 1'b0;
      nowin_o     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            tap         <= '0;
            valid_o     <= 1'b0;
            nowin_o     <= 1'b0;
            best_dly_o  <= '0;
            win_start_o <= '0;
            win_width_o <= '0;
            state       <= ST_CLEAR;
          end
        end
        ST_CLEAR: state <= ST_DWELL;
        ST_DWELL: begin
          if (dwell_done) state <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          if (tap == LAST_TAP) begin
            state <= ST_FINISH;
          end else begin
            tap   <= tap + 1'b1;
            state <= ST_CLEAR;
          end
        end
        ST_FINISH: begin
          if (trk_len != '0) begin
            valid_o     <= 1'b1;
            win_start_o <= trk_start;
            win_width_o <= trk_len;
            best_dly_o  <= centre;
            applied_dly <= centre;
          end else begin
            nowin_o     <= 1'b1;
            applied_dly <= RST_TAP;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dscan_window_finder_chk.sv
module dscan_window_finder_chk #(
  parameter int NUM_TAPS  = 13,
  parameter int RESET_DLY = 0,
  localparam int DLY_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1,
  localparam int LEN_W = $clog2(NUM_TAPS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [DLY_W-1:0] delay_o,
  input logic             clr_o,
  input logic [DLY_W-1:0] best_dly_o,
  input logic [DLY_W-1:0] win_start_o,
  input logic [LEN_W-1:0] win_width_o,
  input logic             valid_o,
  input logic             nowin_o
);
  assert_single_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> !clr_o);

  assert_tap_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(delay_o) < NUM_TAPS);

  assert_window_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (win_width_o != '0) &&
                (int'(win_start_o) + int'(win_width_o) <= NUM_TAPS));

  assert_best_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (best_dly_o >= win_start_o) &&
                (int'(best_dly_o) < int'(win_start_o) + int'(win_width_o)));

  assert_applied_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (delay_o == best_dly_o) && !nowin_o);

  assert_no_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nowin_o |-> !valid_o && (int'(delay_o) == RESET_DLY) && (win_width_o == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o || nowin_o) && !start_i |=>
      $stable(delay_o) && $stable(best_dly_o) && $stable(valid_o) && $stable(nowin_o));
endmodule

bind dscan_window_finder dscan_window_finder_chk #(
  .NUM_TAPS  (NUM_TAPS),
  .RESET_DLY (RESET_DLY)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .delay_o     (delay_o),
  .clr_o       (clr_o),
  .best_dly_o  (best_dly_o),
  .win_start_o (win_start_o),
  .win_width_o (win_width_o),
  .valid_o     (valid_o),
  .nowin_o     (nowin_o)
);

// File: tb/dscan_window_finder_bench.sv
module dscan_window_finder_bench;
  localparam int NT      = 13;
  localparam int DW      = 3;
  localparam int RST_DLY = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        tick_i;
  logic [15:0] ecnt;
  logic [3:0]  delay_o;
  logic        clr_o;
  logic [3:0]  best_dly_o;
  logic [3:0]  win_start_o;
  logic [3:0]  win_width_o;
  logic        valid_o;
  logic        nowin_o;

  int          n_chk = 0;
  int          n_err = 0;
  int          cyc = 0;
  int          tick_mode = 0;
  int          clr_seen = 0;
  int          last_clr = -1;
  logic [NT-1:0] clean_mask = '0;
  bit          finished = 0;

  always #4 clk = ~clk;

  dscan_window_finder #(
    .NUM_TAPS(NT), .ERR_W(16), .DWELL_TICKS(DW), .RESET_DLY(RST_DLY)
  ) u_dscan_window_finder (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
    .err_cnt_i(ecnt), .delay_o(delay_o), .clr_o(clr_o),
    .best_dly_o(best_dly_o), .win_start_o(win_start_o),
    .win_width_o(win_width_o), .valid_o(valid_o), .nowin_o(nowin_o)
  );

  function automatic bit tap_bad(input int d);
    if (d >= NT) return 1'b1;
    return !clean_mask[d];
  endfunction

  // External error counter model: zeroed by clear, counts ticks on dirty taps.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || clr_o) ecnt <= '0;
    else if (tick_i && tap_bad(int'(delay_o)) && ecnt != 16'hffff) ecnt <= ecnt + 16'd1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Tick driver.
  initial begin
    tick_i = 1'b0;
    forever begin
      @(negedge clk);
      case (tick_mode)
        1:       tick_i = 1'b1;
        2:       tick_i = 1'b0;
        default: tick_i = 1'($urandom % 2);
      endcase
    end
  end

  // Clear-strobe monitor: tap order (R2) and spacing under a steady tick (R3).
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && clr_o) begin
        check(int'(delay_o) == clr_seen, "R2", "tap at clear", int'(delay_o), clr_seen);
        if (tick_mode == 1 && last_clr >= 0)
          check(cyc - last_clr == DW + 2, "R3", "clear spacing", cyc - last_clr, DW + 2);
        last_clr = cyc;
        clr_seen++;
      end
    end
  end

  function automatic void exp_window(input logic [NT-1:0] m, output int s, output int w);
    int cs = 0, cl = 0;
    s = 0; w = 0;
    for (int i = 0; i < NT; i++) begin
      if (m[i]) begin
        if (cl == 0) cs = i;
        cl++;
        if (cl > w) begin w = cl; s = cs; end
      end else cl = 0;
    end
  endfunction

  task automatic run_scan(input logic [NT-1:0] m, input int inject, input bit stall);
    int s, w, c;
    bit done = 0;
    clean_mask = m;
    clr_seen = 0;
    last_clr = -1;
    exp_window(m, s, w);
    c = (w == 0) ? RST_DLY : s + (w - 1) / 2;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(!valid_o && !nowin_o, "R10", "flags cleared by start", int'(valid_o) + int'(nowin_o), 0);
    if (stall) begin
      tick_mode = 2;
      repeat (40) @(negedge clk);
      check(clr_seen == 1, "R3", "stalled clears", clr_seen, 1);
      check(delay_o == 4'd0, "R3", "stalled tap", int'(delay_o), 0);
      tick_mode = 0;
    end
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      start_i = (n == inject);
      if (valid_o || nowin_o) begin done = 1; break; end
    end
    start_i = 1'b0;
    check(done, "R2", "sweep completion", int'(done), 1);
    check(clr_seen == NT, "R9", "clear count", clr_seen, NT);
    if (w > 0) begin
      check(valid_o && !nowin_o, "R7", "valid flag", int'(valid_o), 1);
      check(int'(win_start_o) == s, "R5", "window start", int'(win_start_o), s);
      check(int'(win_width_o) == w, "R5", "window width", int'(win_width_o), w);
      check(int'(best_dly_o) == c, "R6", "centre", int'(best_dly_o), c);
      check(int'(delay_o) == c, "R7", "applied delay", int'(delay_o), c);
    end else begin
      check(nowin_o && !valid_o, "R8", "no-window flag", int'(nowin_o), 1);
      check(int'(delay_o) == RST_DLY, "R8", "default delay", int'(delay_o), RST_DLY);
      check(win_width_o == 0 && win_start_o == 0 && best_dly_o == 0, "R8",
            "zero results", int'(win_width_o), 0);
    end
    repeat (5) @(negedge clk);
    check(int'(delay_o) == c, "R10", "held delay", int'(delay_o), c);
    check((w > 0) ? valid_o : nowin_o, "R10", "held flag", 0, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(delay_o) == RST_DLY, "R1", "reset delay", int'(delay_o), RST_DLY);
    check(!valid_o && !nowin_o && !clr_o, "R1", "reset flags",
          int'(valid_o) + int'(nowin_o) + int'(clr_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(delay_o) == RST_DLY && !clr_o, "R1", "after release", int'(delay_o), RST_DLY);

    tick_mode = 1;
    run_scan(13'h0F80, -1, 0);     // R3 spacing, R6 odd width: 7..11 -> 9
    tick_mode = 0;
    run_scan(13'h1FFF, -1, 0);     // all clean: 0..12 -> 6
    run_scan(13'h0000, -1, 0);     // R8 no clean tap
    run_scan(13'h0063, -1, 0);     // R5 tie -> lowest start 0, width 2
    run_scan(13'h1CF3, -1, 0);     // R5 longest 4..7, R6 even width -> 5
    run_scan(13'h1000, -1, 0);     // R4 lone last tap after dirty ones
    run_scan(13'h1C07, 25, 0);     // R9 mid-sweep start ignored
    run_scan(13'h0AAA, -1, 1);     // R3 stall, R4 alternating clean/dirty
    for (int i = 0; i < 30; i++) begin
      logic [NT-1:0] m;
      m = NT'($urandom);
      if (i % 3 == 0) m = m & NT'($urandom);
      if (i % 3 == 1) m = m | NT'($urandom);
      run_scan(m, -1, 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule